// File: doc/BRIEF.md
# Receive Buffer Fill and Frame Length Tracker

This block sits between the receive side of a network controller and system memory. It accepts an incoming frame one byte per cycle, together with start and end markers, and stores it into a chain of fixed-size receive buffers. Each buffer is described by a descriptor that holds a byte start address and a programmed size. Memory writes leave the block one bus word at a time, with a byte-enable mask.

A buffer whose start address is not a multiple of the bus width loses the lanes below that offset. The first word written into such a buffer carries zero-valued dummy bytes in those lanes, and the real frame data starts at the programmed address. A frame that does not fit into one buffer continues in the next descriptor. Every frame begins in a fresh descriptor, even if the previous one still had room.

When a buffer closes, the block emits a one-cycle status write-back. The status marks the first and last segment of the frame, and the last segment also carries the total frame length. Software finds the fill of the last buffer by subtracting the capacities of the earlier buffers from that length. If bytes arrive while no descriptor is held, the block raises a stall flag and does not consume the input.

Top module: `rx_buf_filler`

## Requirements
- R1: After reset, `mem_we` and `wb_valid` are 0, `desc_ready` is 1 and `in_ready` is 0.
- R2: While no descriptor is held, `in_ready` is 0 and `in_valid` raises `stall`. The byte on the input is not consumed and is written later, once a descriptor has been taken.
- R3: An accepted byte goes to lane (address mod `BUS_BYTES`) of the word at the address with its low bits cleared. The word is written with `mem_we` high for one cycle after the byte that ends it. A byte ends the word when it fills the top lane, ends the frame, or fills the buffer. `mem_be` then shows exactly the lanes written.
- R4: For the first word of each buffer, every lane below the start offset has its `mem_be` bit set and a data byte of 0x00.
- R5: A buffer holds `desc_size` minus (`desc_addr` mod `BUS_BYTES`) bytes. A buffer that closes without the end of frame is always exactly full, and the following bytes go to the next descriptor.
- R6: A status write-back (`wb_valid` for one cycle) follows each buffer's final byte. It falls in the same cycle as that buffer's final word write. `wb_fill` is the number of frame bytes stored in that buffer.
- R7: In `wb_status`, bit 9 marks the first segment of a frame and bit 8 the last. Bits 29:16 carry the total frame length, CRC included, on the last segment only, and are 0 otherwise. All other bits are 0.
- R8: After the end of a frame the descriptor is released even if space remains, so the next frame starts at a new descriptor's address.
- R9: `desc_ready` is 1 exactly while no descriptor is held. It returns to 1 in the cycle of the write-back, and a descriptor is taken on `desc_valid && desc_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Frame byte present |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Byte is consumed this cycle when valid |
| stall | output | 1 | Byte waiting with no descriptor held |
| desc_valid | input | 1 | Descriptor offered |
| desc_addr | input | ADDR_W | Buffer start byte address |
| desc_size | input | SIZE_W | Programmed buffer size in bytes |
| desc_ready | output | 1 | Block can take a descriptor |
| mem_we | output | 1 | Word write strobe |
| mem_addr | output | ADDR_W | Word-aligned write address |
| mem_data | output | 8*BUS_BYTES | Write data |
| mem_be | output | BUS_BYTES | Per-byte write enables |
| wb_valid | output | 1 | Descriptor status write-back strobe |
| wb_status | output | 32 | Status word (segment flags, frame length) |
| wb_fill | output | SIZE_W | Frame bytes stored in the closed buffer |

## Verification
Three events can land on one byte: the close of a buffer, the end of a bus word and the end of the frame. When that happens, the final word write and the status write-back must appear in the same cycle. The bench forces these events together with directed frames. One frame is exactly as long as an aligned buffer. Another uses one-byte buffers placed at offset 3, so that every byte opens and closes a buffer, carries dummy lanes and sits in the top lane. Random frames over random offsets and sizes add many more such coincidences. Each write and write-back is compared in order against a byte-level model that the bench drives.

// File: rtl/rxbf_pkg.sv
// Package: shared constants and the status-word packer for the receive buffer filler.
// Assumes frames shorter than 2**FLEN_W bytes.
package rxbf_pkg;
    localparam int FLEN_W   = 14;
    localparam int FLEN_LSB = 16;
    localparam int FS_POS   = 9;
    localparam int LS_POS   = 8;

    // Build the descriptor status word; the length is only reported on the last segment.
    function automatic logic [31:0] pack_status(input logic first, input logic last,
                                                input logic [FLEN_W-1:0] len);
        logic [31:0] s;
        s = '0;
        s[FS_POS] = first;
        s[LS_POS] = last;
        if (last) s[FLEN_LSB +: FLEN_W] = len;
        return s;
    endfunction
endpackage

// File: rtl/rxbf_seg_ctrl.sv
// Segment controller: holds the current descriptor, tracks the next byte address,
// the remaining capacity, the per-buffer fill and the running frame length, and
// issues the status write-back when a buffer closes.
// Assumes desc_size > (desc_addr mod BUS_BYTES) and a well-formed sof/eof stream.
module rxbf_seg_ctrl
    import rxbf_pkg::*;
#(
    parameter int BUS_BYTES = 4,
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 13,
    parameter int LANE_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              desc_valid,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [SIZE_W-1:0] desc_size,
    output logic              desc_ready,
    output logic              in_ready,
    output logic              stall,
    output logic              take,
    output logic              flush,
    output logic              fresh,
    output logic [LANE_W-1:0] lane,
    output logic [ADDR_W-1:0] word_addr,
    output logic              wb_valid,
    output logic [31:0]       wb_status,
    output logic [SIZE_W-1:0] wb_fill
);
    logic              have_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] rem_q;
    logic [SIZE_W-1:0] fill_q;
    logic              fresh_q;
    logic              first_q;
    logic [FLEN_W-1:0] len_q;
    logic [FLEN_W-1:0] len_n;
    logic              last_room;
    logic              buf_end;

    // Handshake and stall flags derive from whether a descriptor is held.
    assign desc_ready = !have_q;
    assign in_ready   = have_q;
    assign stall      = in_valid && !have_q;
    assign take       = in_valid && have_q;

    // Byte placement and the conditions that end a word or a buffer.
    assign lane      = addr_q[LANE_W-1:0];
    assign word_addr = {addr_q[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    assign fresh     = fresh_q;
    assign last_room = (rem_q == SIZE_W'(1));
    assign buf_end   = take && (in_eof || last_room);
    assign flush     = take && (in_eof || last_room || lane == LANE_W'(BUS_BYTES - 1));
    assign len_n     = in_sof ? FLEN_W'(1) : len_q + FLEN_W'(1);

    // Descriptor load, per-byte bookkeeping and buffer close with write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_q    <= 1'b0;
            addr_q    <= '0;
            rem_q     <= '0;
            fill_q    <= '0;
            fresh_q   <= 1'b0;
            first_q   <= 1'b1;
            len_q     <= '0;
            wb_valid  <= 1'b0;
            wb_status <= '0;
            wb_fill   <= '0;
        end else begin
            wb_valid <= 1'b0;
            if (desc_valid && !have_q) begin
                have_q  <= 1'b1;
                addr_q  <= desc_addr;
                rem_q   <= desc_size - SIZE_W'(desc_addr[LANE_W-1:0]);
                fill_q  <= '0;
                fresh_q <= 1'b1;
            end else if (take) begin
                addr_q  <= addr_q + ADDR_W'(1);
                rem_q   <= rem_q - SIZE_W'(1);
                fill_q  <= fill_q + SIZE_W'(1);
                fresh_q <= 1'b0;
                len_q   <= in_eof ? '0 : len_n;
                if (buf_end) begin
                    have_q    <= 1'b0;
                    wb_valid  <= 1'b1;
                    wb_status <= pack_status(first_q, in_eof, len_n);
                    wb_fill   <= fill_q + SIZE_W'(1);
                    first_q   <= in_eof;
                end
            end
        end
    end
endmodule

// File: rtl/rxbf_word_pack.sv
// Word packer: assembles accepted bytes into one bus word with byte enables,
// fills lanes below the start offset with dummy zero bytes on a fresh buffer,
// and issues a registered memory write when the controller flushes the word.
// Assumes flush is only raised together with take.
module rxbf_word_pack #(
    parameter int BUS_BYTES = 4,
    parameter int ADDR_W    = 32,
    parameter int LANE_W    = 2,
    localparam int DATA_W   = 8 * BUS_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              flush,
    input  logic              fresh,
    input  logic [LANE_W-1:0] lane,
    input  logic [7:0]        byte_in,
    input  logic [ADDR_W-1:0] word_addr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [BUS_BYTES-1:0] mem_be
);
    logic [DATA_W-1:0]    acc_d, nxt_d;
    logic [BUS_BYTES-1:0] acc_be, nxt_be;

    // Merge the incoming byte (and any dummy lanes) into the partial word.
    always_comb begin
        nxt_d  = acc_d;
        nxt_be = acc_be;
        for (int i = 0; i < BUS_BYTES; i++) begin
            if (fresh && (LANE_W'(i) < lane)) begin
                nxt_d[i*8 +: 8] = 8'h00;
                nxt_be[i]       = 1'b1;
            end
            if (LANE_W'(i) == lane) begin
                nxt_d[i*8 +: 8] = byte_in;
                nxt_be[i]       = 1'b1;
            end
        end
    end

    // Hold the partial word or send it to memory and start an empty one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_d    <= '0;
            acc_be   <= '0;
            mem_we   <= 1'b0;
            mem_addr <= '0;
            mem_data <= '0;
            mem_be   <= '0;
        end else begin
            mem_we <= 1'b0;
            if (take) begin
                if (flush) begin
                    mem_we   <= 1'b1;
                    mem_addr <= word_addr;
                    mem_data <= nxt_d;
                    mem_be   <= nxt_be;
                    acc_d    <= '0;
                    acc_be   <= '0;
                end else begin
                    acc_d  <= nxt_d;
                    acc_be <= nxt_be;
                end
            end
        end
    end
endmodule

// File: rtl/rx_buf_filler.sv
// Receive buffer filler top: joins the segment controller and the word packer.
// Writes a byte stream into descriptor-described buffers, one bus word at a time,
// and reports per-buffer fill and the frame length on the last segment.
// Assumes BUS_BYTES is a power of two, at least 2.
module rx_buf_filler #(
    parameter int BUS_BYTES = 4,
    parameter int ADDR_W    = 32,
    parameter int SIZE_W    = 13,
    localparam int LANE_W   = $clog2(BUS_BYTES),
    localparam int DATA_W   = 8 * BUS_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [7:0]           in_data,
    input  logic                 in_sof,
    input  logic                 in_eof,
    output logic                 in_ready,
    output logic                 stall,
    input  logic                 desc_valid,
    input  logic [ADDR_W-1:0]    desc_addr,
    input  logic [SIZE_W-1:0]    desc_size,
    output logic                 desc_ready,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_data,
    output logic [BUS_BYTES-1:0] mem_be,
    output logic                 wb_valid,
    output logic [31:0]          wb_status,
    output logic [SIZE_W-1:0]    wb_fill
);
    logic              take, flush, fresh;
    logic [LANE_W-1:0] lane;
    logic [ADDR_W-1:0] word_addr;

    rxbf_seg_ctrl #(
        .BUS_BYTES(BUS_BYTES), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LANE_W(LANE_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .desc_valid(desc_valid), .desc_addr(desc_addr), .desc_size(desc_size),
        .desc_ready(desc_ready), .in_ready(in_ready), .stall(stall),
        .take(take), .flush(flush), .fresh(fresh), .lane(lane), .word_addr(word_addr),
        .wb_valid(wb_valid), .wb_status(wb_status), .wb_fill(wb_fill)
    );

    rxbf_word_pack #(
        .BUS_BYTES(BUS_BYTES), .ADDR_W(ADDR_W), .LANE_W(LANE_W)
    ) u_pack (
        .clk(clk), .rst_n(rst_n),
        .take(take), .flush(flush), .fresh(fresh), .lane(lane),
        .byte_in(in_data), .word_addr(word_addr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be)
    );
endmodule

// File: rtl/rxbf_checker.sv
// Checker: temporal properties of the receive buffer filler, bound to the top.
// Tracks the capacity of the held descriptor and the previous segment's last flag.
module rxbf_checker #(
    parameter int BUS_BYTES = 4,
    parameter int SIZE_W    = 13,
    localparam int LANE_W   = $clog2(BUS_BYTES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 desc_valid,
    input logic                 desc_ready,
    input logic [LANE_W-1:0]    desc_off,
    input logic [SIZE_W-1:0]    desc_size,
    input logic                 mem_we,
    input logic [LANE_W-1:0]    mem_addr_lo,
    input logic [BUS_BYTES-1:0] mem_be,
    input logic                 wb_valid,
    input logic [31:0]          wb_status,
    input logic [SIZE_W-1:0]    wb_fill
);
    logic [SIZE_W-1:0] cap_q;
    logic              prev_last_q;

    // Capture the capacity of each accepted descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else if (desc_valid && desc_ready) cap_q <= desc_size - SIZE_W'(desc_off);
    end

    // Remember whether the last write-back closed a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_last_q <= 1'b1;
        else if (wb_valid) prev_last_q <= wb_status[8];
    end

    // R3: every word write is aligned and enables at least one lane.
    a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr_lo == '0 && mem_be != '0));

    // R6: a write-back always comes with the final word write of its buffer.
    a_r6_wb_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> mem_we);

    // R5: a non-last buffer is always completely full.
    a_r5_full_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_status[8]) |-> (wb_fill == cap_q));

    // R9: the descriptor is released when its write-back appears.
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> desc_ready);

    // R7: length is zero on non-last segments.
    a_r7_len_last_only: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_status[8]) |-> (wb_status[29:16] == 14'd0));

    // R7: unused status bits stay zero.
    a_r7_clean_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_status[31:30] == 2'b0 && wb_status[15:10] == 6'b0
                      && wb_status[7:0] == 8'b0));

    // R7: first-segment flag set exactly after a frame ended.
    a_r7_first_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_status[9] == prev_last_q));
endmodule

bind rx_buf_filler rxbf_checker #(.BUS_BYTES(BUS_BYTES), .SIZE_W(SIZE_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_off(desc_addr[LANE_W-1:0]), .desc_size(desc_size),
    .mem_we(mem_we), .mem_addr_lo(mem_addr[LANE_W-1:0]), .mem_be(mem_be),
    .wb_valid(wb_valid), .wb_status(wb_status), .wb_fill(wb_fill)
);

// File: tb/rx_buf_filler_bench.sv
// Bench: directed corner frames plus seeded random frames, compared against a
// byte-level expected model driven from the requirements.
module rx_buf_filler_bench;
    localparam int CLK_PERIOD = 10;
    localparam int BB     = 4;
    localparam int AW     = 32;
    localparam int SW     = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_ready, stall;
    logic          desc_valid = 1'b0;
    logic [AW-1:0] desc_addr = '0;
    logic [SW-1:0] desc_size = '0;
    logic          desc_ready;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_data;
    logic [BB-1:0] mem_be;
    logic          wb_valid;
    logic [31:0]   wb_status;
    logic [SW-1:0] wb_fill;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_buf_filler #(.BUS_BYTES(BB), .ADDR_W(AW), .SIZE_W(SW)) u_rx_buf_filler (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_ready(in_ready), .stall(stall),
        .desc_valid(desc_valid), .desc_addr(desc_addr), .desc_size(desc_size),
        .desc_ready(desc_ready),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
        .wb_valid(wb_valid), .wb_status(wb_status), .wb_fill(wb_fill)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Expected model state.
    logic [AW-1:0] m_addr;
    int            m_rem, m_fill, m_len;
    bit            m_fresh, m_first = 1'b1;
    logic [31:0]   m_d;
    logic [BB-1:0] m_be;
    logic [AW-1:0] qw_addr[$];
    logic [31:0]   qw_data[$];
    logic [BB-1:0] qw_be[$];
    logic [31:0]   qs_stat[$];
    int            qs_fill[$];

    function automatic int exp_status(input bit first, input bit last, input int len);
        return ((last ? (len & 16'h3fff) : 0) << 16) | (int'(first) << 9) | (int'(last) << 8);
    endfunction

    task automatic model_load(input logic [AW-1:0] a, input int size);
        m_addr  = a;
        m_rem   = size - int'(a % BB);
        m_fill  = 0;
        m_fresh = 1'b1;
        m_d     = '0;
        m_be    = '0;
    endtask

    task automatic model_accept(input logic [7:0] b, input bit eof);
        int lane;
        lane = int'(m_addr % BB);
        if (m_fresh)
            for (int l = 0; l < lane; l++) begin
                m_d[l*8 +: 8] = 8'h00;
                m_be[l] = 1'b1;
            end
        m_d[lane*8 +: 8] = b;
        m_be[lane] = 1'b1;
        m_fresh = 1'b0;
        m_len++; m_fill++; m_rem--;
        if (lane == BB-1 || eof || m_rem == 0) begin
            qw_addr.push_back(m_addr - AW'(lane));
            qw_data.push_back(m_d);
            qw_be.push_back(m_be);
            m_d = '0; m_be = '0;
        end
        if (eof || m_rem == 0) begin
            qs_stat.push_back(exp_status(m_first, eof, m_len));
            qs_fill.push_back(m_fill);
            m_first = eof;
            if (eof) m_len = 0;
        end
        m_addr = m_addr + 1;
    endtask

    // Monitor: compare each write and write-back with the model, in order.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                if (qw_addr.size() == 0) check(0, "R3", "unexpected write", mem_addr, 0);
                else begin
                    check(mem_addr == qw_addr[0], "R3", "write address", mem_addr, qw_addr[0]);
                    check(mem_data == qw_data[0], "R3", "write data", mem_data, qw_data[0]);
                    check(mem_be == qw_be[0], "R4", "byte enables", mem_be, qw_be[0]);
                    void'(qw_addr.pop_front()); void'(qw_data.pop_front()); void'(qw_be.pop_front());
                end
            end
            if (wb_valid) begin
                check(mem_we, "R6", "write-back without final write", mem_we, 1);
                if (qs_stat.size() == 0) check(0, "R6", "unexpected write-back", wb_status, 0);
                else begin
                    check(wb_status == qs_stat[0], "R7", "status word", wb_status, qs_stat[0]);
                    check(int'(wb_fill) == qs_fill[0], "R5", "buffer fill", wb_fill, qs_fill[0]);
                    void'(qs_stat.pop_front()); void'(qs_fill.pop_front());
                end
            end
        end
    end

    // Descriptor source configuration.
    bit            cfg_fixed = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    int            cfg_size = 8;
    int            cfg_delay = 0;
    logic [AW-1:0] rnd_base = 32'h1000;

    task automatic send_frame(input int n);
        int k = 0;
        int wait_c = cfg_delay;
        while (k < n) begin
            logic [7:0] b;
            @(negedge clk);
            b = 8'($urandom);
            desc_valid = 1'b0;
            in_valid = 1'b1; in_data = b;
            in_sof = (k == 0); in_eof = (k == n - 1);
            if (desc_ready) begin
                if (wait_c > 0) begin
                    wait_c--;
                    #1;
                    check(stall && !in_ready, "R2", "stall without descriptor",
                          {stall, in_ready}, 2'b10);
                end else begin
                    logic [AW-1:0] a;
                    int sz;
                    if (cfg_fixed) begin
                        a = cfg_addr; sz = cfg_size;
                    end else begin
                        rnd_base = rnd_base + 32'h100;
                        a = rnd_base + AW'($urandom_range(0, BB - 1));
                        sz = $urandom_range(4, 20);
                    end
                    desc_valid = 1'b1; desc_addr = a; desc_size = SW'(sz);
                    model_load(a, sz);
                    wait_c = (cfg_delay > 0) ? $urandom_range(0, cfg_delay) : 0;
                end
            end
            #1;
            if (in_ready) begin
                model_accept(b, k == n - 1);
                k++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; desc_valid = 1'b0;
        check(desc_ready, "R8", "descriptor released after frame end", desc_ready, 1);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!mem_we && !wb_valid, "R1", "no write after reset", {mem_we, wb_valid}, 0);
        check(desc_ready && !in_ready, "R1", "ready flags after reset",
              {desc_ready, in_ready}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        check(desc_ready, "R9", "desc_ready while empty", desc_ready, 1);

        // Directed: aligned buffer filled exactly by the frame.
        cfg_fixed = 1'b1; cfg_addr = 32'h100; cfg_size = 8; cfg_delay = 0;
        send_frame(8);
        // Directed: one-byte buffers at offset 3 (dummy lanes, top lane, buffer end together).
        cfg_addr = 32'h203; cfg_size = 4;
        send_frame(3);
        // Directed: short frames in a large buffer, each must start afresh (R8).
        cfg_addr = 32'h302; cfg_size = 64;
        send_frame(2);
        send_frame(5);
        // Directed: late descriptors provoke stall (R2).
        cfg_addr = 32'h401; cfg_size = 6; cfg_delay = 3;
        send_frame(13);

        // Random frames over random offsets, sizes and descriptor delays.
        cfg_fixed = 1'b0;
        for (int f = 0; f < 40; f++) begin
            cfg_delay = $urandom_range(0, 3);
            send_frame($urandom_range(1, 40));
        end

        repeat (4) @(negedge clk);
        check(qw_addr.size() == 0, "R3", "pending expected writes", qw_addr.size(), 0);
        check(qs_stat.size() == 0, "R6", "pending expected write-backs", qs_stat.size(), 0);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_fail++;
        $display("FAIL R6 watchdog expired: actual 0 expected 1");
        finish_run();
    end
endmodule